// File: doc/BRIEF.md
# Dual-Spacer Dual-Rail Link

This block models, on a clock, a two-wire channel where every data bit is sent as a token and each token is framed by spacers. The spacer between tokens is not always the same. It swaps between all-zero and all-one each time. Because of this, each wire changes level exactly once per phase whatever the data, and the switching activity on the two wires stays equal.

The block has two halves. The encoder takes a one-bit stream over a valid/ready handshake and drives a transmit rail pair. The checker watches a receive rail pair, which can be looped back from the transmit side or fed from elsewhere. It returns the decoded bits, flags protocol violations, and counts the level changes on each receive wire.

The encoder is a four-state machine:
- `ENC_HOLD_ZERO` outputs the all-zero spacer and waits.
- `ENC_TOKEN_THEN_ONE` outputs a token that will be followed by the all-one spacer.
- `ENC_HOLD_ONE` outputs the all-one spacer and waits.
- `ENC_TOKEN_THEN_ZERO` outputs a token that will be followed by the all-zero spacer.

Its transitions are:
- Accept: from a hold state to the matching token state when a bit is offered.
- Close: from a token state to the opposite hold state after one cycle.

The checker is also a four-state machine. It remembers the last symbol seen and the type of the last spacer:
- `MON_SP_ZERO` and `MON_SP_ONE`: the last symbol was a spacer of that type.
- `MON_TK_AFTER_ZERO` and `MON_TK_AFTER_ONE`: the last symbol was a token, and the spacer before it had that type.

The checker acts only when the receive pair changes value. Its transitions are:
- Decode: from a spacer state to a token state.
- Close: from a token state to the spacer of the other type.
- On a violation, it moves to the state that matches the symbol it saw (resync).

Top module: `dsdr_link`

## Requirements
- R1: Under reset and on the first cycle after it, the transmit pair is 00, `in_ready` is 1, `out_valid` and `err_flag` are 0, and both transition counts are 0. The checker starts out treating the receive pair as having last shown the all-zero spacer.
- R2: The rail codes are as follows, with rail1 written first:
  - A data 0 token is rail1=0, rail0=1.
  - A data 1 token is rail1=1, rail0=0.
  - The all-zero spacer is 00 and the all-one spacer is 11.
- R3: The encoder accepts a bit only while it is outputting a spacer (`in_ready`=1). A token stays on the pair for exactly one cycle, and `in_ready` is 0 during that cycle. A valid bit held during the token cycle is not taken until the next spacer cycle.
- R4: After every token, the encoder outputs the spacer of the other type from the spacer before that token. The first spacer after reset is all-zero, so the first spacer after a token is all-one.
- R5: With no bit offered, the encoder holds its current spacer unchanged on the pair.
- R6: When the receive pair changes from a spacer to a token, the checker reports the bit on the cycle after the sampling edge: `out_valid`=1 for one cycle and `out_bit` equal to rail1.
- R7: A change from one token directly to the other token raises `err_flag` with `err_code`=1 and gives no `out_valid`.
- R8: A change from one spacer type directly to the other raises `err_flag` with `err_code`=2.
- R9: After a token, a spacer of the same type as the spacer before that token raises `err_flag` with `err_code`=3.
- R10: Each transition count goes up by one for every level change on its receive wire. In loopback, after n tokens have been sent and closed, both counts equal n.
- R11: After any violation, the checker takes the observed symbol as its new reference. The next correctly alternating symbols decode without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Offered data bit |
| in_ready | output | 1 | Encoder is in a spacer phase and will take a bit |
| tx_rail1 | output | 1 | Transmit rail 1 |
| tx_rail0 | output | 1 | Transmit rail 0 |
| rx_rail1 | input | 1 | Receive rail 1 |
| rx_rail0 | input | 1 | Receive rail 0 |
| out_valid | output | 1 | One-cycle pulse when a decoded bit is available |
| out_bit | output | 1 | Decoded bit |
| err_flag | output | 1 | One-cycle pulse on a protocol violation |
| err_code | output | 2 | Violation kind: 1 token-token, 2 spacer-spacer, 3 repeated spacer type |
| tog_cnt1 | output | CNT_W | Level changes seen on receive rail 1 |
| tog_cnt0 | output | CNT_W | Level changes seen on receive rail 0 |

## Verification
The assertions check these properties on every cycle:
- The transmit pair shows a token exactly when `in_ready` is low, and that token lasts one cycle.
- An idle spacer stays stable.
- The spacer after a token differs from the spacer before it.
- A decoded bit always comes from a token sampled on the previous edge, and two decoded bits never arrive on back-to-back cycles.
- A spacer-to-spacer error follows a spacer sample.
- Each count rises by at most one per cycle.

Only the bench scenarios can show the rest. These are the end-to-end bit order through loopback, the equal transition totals after a known number of tokens, and each violation code produced by a forced receive pattern. They also cover the checker's resynchronisation after errors and the handling of a valid held high through a token cycle.

// File: rtl/dsdr_pkg.sv
package dsdr_pkg;

    typedef struct packed {
        logic hi;   // rail 1
        logic lo;   // rail 0
    } rail_pair_t;

    localparam rail_pair_t SPACER_ZERO = '{hi: 1'b0, lo: 1'b0};
    localparam rail_pair_t SPACER_ONE  = '{hi: 1'b1, lo: 1'b1};

    typedef enum logic [1:0] {
        ENC_HOLD_ZERO,
        ENC_TOKEN_THEN_ONE,
        ENC_HOLD_ONE,
        ENC_TOKEN_THEN_ZERO
    } enc_state_t;

    typedef enum logic [1:0] {
        MON_SP_ZERO,
        MON_SP_ONE,
        MON_TK_AFTER_ZERO,
        MON_TK_AFTER_ONE
    } mon_state_t;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_TOK_TOK   = 2'd1,
        ERR_SP_SP     = 2'd2,
        ERR_SP_REPEAT = 2'd3
    } err_kind_t;

    function automatic rail_pair_t token_of(input logic b);
        rail_pair_t p;
        p.hi = b;
        p.lo = ~b;
        return p;
    endfunction

    function automatic logic is_spacer(input rail_pair_t p);
        return p.hi == p.lo;
    endfunction

endpackage

// File: rtl/dsdr_enc.sv
module dsdr_enc
    import dsdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output rail_pair_t rails
);

    enc_state_t state_q, state_d;
    rail_pair_t rails_q, rails_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_HOLD_ZERO:       if (in_valid) state_d = ENC_TOKEN_THEN_ONE;
            ENC_TOKEN_THEN_ONE:  state_d = ENC_HOLD_ONE;
            ENC_HOLD_ONE:        if (in_valid) state_d = ENC_TOKEN_THEN_ZERO;
            ENC_TOKEN_THEN_ZERO: state_d = ENC_HOLD_ZERO;
            default:             state_d = ENC_HOLD_ZERO;
        endcase
    end

    // output code for the state being entered
    always_comb begin
        rails_d = rails_q;
        unique case (state_d)
            ENC_HOLD_ZERO:       rails_d = SPACER_ZERO;
            ENC_HOLD_ONE:        rails_d = SPACER_ONE;
            ENC_TOKEN_THEN_ONE,
            ENC_TOKEN_THEN_ZERO: if (state_d != state_q) rails_d = token_of(in_bit);
            default:             rails_d = SPACER_ZERO;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENC_HOLD_ZERO;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) rails_q <= SPACER_ZERO;
        else        rails_q <= rails_d;
    end

    assign in_ready = (state_q == ENC_HOLD_ZERO) || (state_q == ENC_HOLD_ONE);
    assign rails    = rails_q;

endmodule

// File: rtl/dsdr_mon.sv
module dsdr_mon
    import dsdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rail_pair_t rx,
    output logic       out_valid,
    output logic       out_bit,
    output logic       err_flag,
    output err_kind_t  err_code
);

    mon_state_t state_q, state_d;
    rail_pair_t prev_q;
    logic       changed;
    logic       evt_valid;
    err_kind_t  evt_err;

    assign changed = (rx != prev_q);

    // symbol classification and next state, acting only on a change
    always_comb begin
        state_d   = state_q;
        evt_valid = 1'b0;
        evt_err   = ERR_NONE;
        if (changed) begin
            unique case (state_q)
                MON_SP_ZERO: begin
                    if (is_spacer(rx)) begin
                        evt_err = ERR_SP_SP;
                        state_d = MON_SP_ONE;
                    end else begin
                        evt_valid = 1'b1;
                        state_d   = MON_TK_AFTER_ZERO;
                    end
                end
                MON_SP_ONE: begin
                    if (is_spacer(rx)) begin
                        evt_err = ERR_SP_SP;
                        state_d = MON_SP_ZERO;
                    end else begin
                        evt_valid = 1'b1;
                        state_d   = MON_TK_AFTER_ONE;
                    end
                end
                MON_TK_AFTER_ZERO: begin
                    if (!is_spacer(rx)) begin
                        evt_err = ERR_TOK_TOK;
                    end else if (rx == SPACER_ONE) begin
                        state_d = MON_SP_ONE;
                    end else begin
                        evt_err = ERR_SP_REPEAT;
                        state_d = MON_SP_ZERO;
                    end
                end
                MON_TK_AFTER_ONE: begin
                    if (!is_spacer(rx)) begin
                        evt_err = ERR_TOK_TOK;
                    end else if (rx == SPACER_ZERO) begin
                        state_d = MON_SP_ZERO;
                    end else begin
                        evt_err = ERR_SP_REPEAT;
                        state_d = MON_SP_ONE;
                    end
                end
                default: state_d = MON_SP_ZERO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_SP_ZERO;
            prev_q  <= SPACER_ZERO;
        end else begin
            state_q <= state_d;
            prev_q  <= rx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            err_flag  <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            out_valid <= evt_valid;
            if (evt_valid) out_bit <= rx.hi;
            err_flag  <= (evt_err != ERR_NONE);
            err_code  <= evt_err;
        end
    end

endmodule

// File: rtl/dsdr_toggle_cnt.sv
module dsdr_toggle_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rail,
    output logic [CNT_W-1:0] cnt
);

    logic last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            cnt    <= '0;
        end else begin
            last_q <= rail;
            if (rail != last_q) cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dsdr_link.sv
module dsdr_link
    import dsdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             tx_rail1,
    output logic             tx_rail0,
    input  logic             rx_rail1,
    input  logic             rx_rail0,
    output logic             out_valid,
    output logic             out_bit,
    output logic             err_flag,
    output logic [1:0]       err_code,
    output logic [CNT_W-1:0] tog_cnt1,
    output logic [CNT_W-1:0] tog_cnt0
);

    localparam int N_RAILS = 2;

    rail_pair_t              tx_pair;
    rail_pair_t              rx_pair;
    err_kind_t               err_kind;
    logic [N_RAILS-1:0]      rx_bus;
    logic [CNT_W-1:0]        cnt_bus [N_RAILS];

    dsdr_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .rails    (tx_pair)
    );

    assign tx_rail1 = tx_pair.hi;
    assign tx_rail0 = tx_pair.lo;
    assign rx_pair  = '{hi: rx_rail1, lo: rx_rail0};

    dsdr_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx        (rx_pair),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .err_flag  (err_flag),
        .err_code  (err_kind)
    );

    assign err_code = err_kind;
    assign rx_bus   = {rx_rail1, rx_rail0};

    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail_cnt
        dsdr_toggle_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .rail  (rx_bus[g]),
            .cnt   (cnt_bus[g])
        );
    end

    assign tog_cnt1 = cnt_bus[1];
    assign tog_cnt0 = cnt_bus[0];

endmodule

// File: rtl/dsdr_link_chk.sv
module dsdr_link_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             tx_rail1,
    input logic             tx_rail0,
    input logic             rx_rail1,
    input logic             rx_rail0,
    input logic             out_valid,
    input logic             out_bit,
    input logic             err_flag,
    input logic [1:0]       err_code,
    input logic [CNT_W-1:0] tog_cnt1,
    input logic [CNT_W-1:0] tog_cnt0
);

    // R2
    token_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (tx_rail1 != tx_rail0));

    // R2
    spacer_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (tx_rail1 == tx_rail0));

    // R3
    token_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R4
    spacer_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (tx_rail1 != $past(tx_rail1, 2)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ($stable(tx_rail1) && $stable(tx_rail0)));

    // R6
    decode_from_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(rx_rail1) != $past(rx_rail0)));

    // R6
    decode_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == $past(rx_rail1)));

    // R6
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    sp_sp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && err_code == 2'd2) |-> ($past(rx_rail1) == $past(rx_rail0)));

    // R10
    cnt1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_cnt1 == $past(tog_cnt1)) || (tog_cnt1 == $past(tog_cnt1) + CNT_W'(1)));

    // R10
    cnt0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_cnt0 == $past(tog_cnt0)) || (tog_cnt0 == $past(tog_cnt0) + CNT_W'(1)));

endmodule

bind dsdr_link dsdr_link_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_rail1  (tx_rail1),
    .tx_rail0  (tx_rail0),
    .rx_rail1  (rx_rail1),
    .rx_rail0  (rx_rail0),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .tog_cnt1  (tog_cnt1),
    .tog_cnt0  (tog_cnt0)
);

// File: tb/dsdr_link_tb.sv
module dsdr_link_tb;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, in_valid, in_bit;
    logic inj, inj1, inj0;
    wire  in_ready, tx1, tx0, out_valid, out_bit, err_flag;
    wire  [1:0] err_code;
    wire  [CNT_W-1:0] cnt1, cnt0;
    wire  rx1 = inj ? inj1 : tx1;
    wire  rx0 = inj ? inj0 : tx0;

    dsdr_link #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .tx_rail1(tx1), .tx_rail0(tx0),
        .rx_rail1(rx1), .rx_rail0(rx0), .out_valid(out_valid), .out_bit(out_bit),
        .err_flag(err_flag), .err_code(err_code), .tog_cnt1(cnt1), .tog_cnt0(cnt0)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    bit   exp_q[$];
    logic exp_sp;
    int   ntok;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected decode actual=%0b expected=none", out_bit);
                end else begin
                    chk("R6 decoded bit", out_bit, exp_q.pop_front());
                end
            end
            if (!inj && err_flag) chk("R4 loopback error flag", err_flag, 0);
        end
    end

    task automatic send_bit(input bit b);
        @(negedge clk);
        in_valid = 1'b1; in_bit = b;
        @(negedge clk);
        in_valid = 1'b0;
        exp_q.push_back(b);
        chk("R2 token code", {tx1, tx0}, b ? 2'b10 : 2'b01);
        chk("R3 ready low in token", in_ready, 0);
        ntok++;
        exp_sp = ~exp_sp;
        @(negedge clk);
        chk("R4 alternate spacer", {tx1, tx0}, {exp_sp, exp_sp});
        chk("R3 ready back", in_ready, 1);
    endtask

    // called at a negedge; applies a receive pattern and waits for the result
    task automatic drive_rx(input logic r1, input logic r0);
        inj1 = r1; inj0 = r0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_bit = 0; inj = 0; inj1 = 0; inj0 = 0;
        exp_sp = 1'b0; ntok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 tx pair", {tx1, tx0}, 2'b00);
        chk("R1 ready", in_ready, 1);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 err_flag", err_flag, 0);
        chk("R1 counts", {cnt1, cnt0}, 0);

        // R2 R4 R6: loopback patterns
        send_bit(1); send_bit(0); send_bit(0); send_bit(1);
        send_bit(1); send_bit(1); send_bit(0);

        // R5: idle hold
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R5 idle spacer held", {tx1, tx0}, {exp_sp, exp_sp});
        end

        // R3: valid held through a token cycle
        in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        chk("R3 token 1", {tx1, tx0}, 2'b10);
        chk("R3 ready low", in_ready, 0);
        exp_q.push_back(1'b1); ntok++; exp_sp = ~exp_sp;
        in_bit = 1'b0;
        @(negedge clk);
        chk("R3 held valid ignored in token", {tx1, tx0}, {exp_sp, exp_sp});
        chk("R3 ready in spacer", in_ready, 1);
        exp_q.push_back(1'b0);
        @(negedge clk);
        chk("R3 next token", {tx1, tx0}, 2'b01);
        in_valid = 1'b0; ntok++; exp_sp = ~exp_sp;
        @(negedge clk);
        chk("R4 spacer after held token", {tx1, tx0}, {exp_sp, exp_sp});

        // R10: equal switching
        repeat (2) @(negedge clk);
        chk("R10 rail1 count", cnt1, ntok);
        chk("R10 rail0 count", cnt0, ntok);
        chk("R6 scoreboard drained", exp_q.size(), 0);

        // protocol violations on the receive side
        inj1 = exp_sp; inj0 = exp_sp; inj = 1'b1;
        drive_rx(exp_sp, exp_sp);
        chk("R11 no error on steady spacer", err_flag, 0);
        exp_q.push_back(1'b0);
        drive_rx(1'b0, 1'b1);
        chk("R6 injected decode", out_valid, 1);
        drive_rx(1'b1, 1'b0);
        chk("R7 token-token flag", err_flag, 1);
        chk("R7 token-token code", err_code, 1);
        chk("R7 no decode", out_valid, 0);
        drive_rx(exp_sp, exp_sp);
        chk("R9 repeat spacer flag", err_flag, 1);
        chk("R9 repeat spacer code", err_code, 3);
        drive_rx(~exp_sp, ~exp_sp);
        chk("R8 spacer-spacer flag", err_flag, 1);
        chk("R8 spacer-spacer code", err_code, 2);
        exp_q.push_back(1'b1);
        drive_rx(1'b1, 1'b0);
        chk("R11 resync decode", out_valid, 1);
        chk("R11 resync no error", err_flag, 0);
        drive_rx(exp_sp, exp_sp);
        chk("R11 resync spacer ok", err_flag, 0);
        inj = 1'b0;
        @(negedge clk);
        chk("R11 back to loopback", err_flag, 0);

        send_bit(0); send_bit(1);
        repeat (3) @(negedge clk);
        chk("R6 final drain", exp_q.size(), 0);

        done = 1;
        finish_run();
    end

endmodule